// File: doc/BRIEF.md
# Input Capture Edge Detector

This block is the input stage of a timer channel. It takes an asynchronous pin and brings it into the clock domain through a short synchroniser chain. It then looks for the kind of transition that software has selected. When that transition occurs, it copies the value of a free-running counter into a capture register. Each capture produces a one-cycle strobe. It also sets a status flag that stays high until software clears it.

There are four transition types:

- every edge;
- rising edges only;
- falling edges only;
- a complete pulse, where the capture happens on the second edge of the pulse.

For the pulse type, the block keeps an internal armed flag. The armed flag is set by the first edge. The second edge clears it and produces the capture. A change of type clears the armed flag. So does turning the channel off. When the channel is off, no capture activity of any kind takes place.

Top module: `icap_edge_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `cap_value` is zero, `cap_strobe` is low and `cap_flag` is low.
- R2: With `cap_mode` = 2'b00, every change of the pin level causes a capture.
- R3: With `cap_mode` = 2'b01, only a low-to-high change of the pin causes a capture.
- R4: With `cap_mode` = 2'b10, only a high-to-low change of the pin causes a capture.
- R5: With `cap_mode` = 2'b11, edges alternate between arming and capturing. The first edge after the armed flag was cleared only arms. The next edge captures and disarms.
- R6: Any change of `cap_mode` clears the pulse-mode armed flag. After such a change, the next edge in mode 2'b11 only arms.
- R7: While `chan_en` is low, pin changes cause no strobe, leave `cap_value` and `cap_flag` untouched, and clear the pulse-mode armed flag.
- R8: On a capture, `cap_value` takes the value of `count_in` at the clock edge that raises `cap_strobe`. At all other times `cap_value` holds its value.
- R9: With two synchroniser stages, `cap_strobe` is high for exactly the third rising clock edge after a qualifying pin change and low on the next one. This holds when no further capture follows.
- R10: `cap_flag` is set by a capture and stays set until `flag_clr` is high at a clock edge. When a capture and `flag_clr` coincide, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; low blocks all capture activity |
| cap_mode | input | 2 | Transition type: 00 any, 01 rising, 10 falling, 11 pulse |
| pin_async | input | 1 | Asynchronous input pin |
| count_in | input | CNT_W | Free-running counter value |
| flag_clr | input | 1 | Clears the sticky capture flag |
| cap_value | output | CNT_W | Captured counter value |
| cap_strobe | output | 1 | One-cycle pulse per capture |
| cap_flag | output | 1 | Sticky capture status |

## Verification
Each transition type is driven with the same rise-then-fall pair of pin changes. This shows which edge directions each type accepts. In pulse mode, a longer train of edges checks that arming and capturing alternate. Other runs break an armed pulse with a mode round-trip or with a short disable, to show that the armed flag is dropped. A distinct counter value at each step tells a fresh capture apart from a held one. Firing a capture in the same cycle as a clear tells whether set or clear has priority on the flag.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        CAP_ANY   = 2'b00,
        CAP_RISE  = 2'b01,
        CAP_FALL  = 2'b10,
        CAP_PULSE = 2'b11
    } cap_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_info_t;

    function automatic edge_info_t classify_edge(input logic cur, input logic prev);
        edge_info_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

    // Event for the three edge-direction modes; pulse mode is handled with its arm state.
    function automatic logic direct_hit(input cap_mode_e m, input edge_info_t e);
        logic hit;
        case (m)
            CAP_ANY:  hit = e.rise | e.fall;
            CAP_RISE: hit = e.rise;
            CAP_FALL: hit = e.fall;
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/icap_edge_qual.sv
module icap_edge_qual
    import icap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] mode_raw,
    input  logic       lvl,
    output logic       fire
);
    cap_mode_e  mode;
    cap_mode_e  mode_q;
    logic       lvl_d;
    logic       armed;
    edge_info_t ed;
    logic       any_edge;
    logic       mode_moved;
    logic       pulse_hit;

    assign mode       = cap_mode_e'(mode_raw);
    assign ed         = classify_edge(lvl, lvl_d);
    assign any_edge   = ed.rise | ed.fall;
    assign mode_moved = (mode != mode_q);
    assign pulse_hit  = (mode == CAP_PULSE) && !mode_moved && any_edge && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_d  <= 1'b0;
            mode_q <= CAP_ANY;
        end else begin
            lvl_d  <= lvl;
            mode_q <= mode;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (!en || mode_moved)
            armed <= 1'b0;
        else if (mode == CAP_PULSE && any_edge)
            armed <= ~armed;
    end

    always_comb begin
        fire = 1'b0;
        if (en) begin
            if (mode == CAP_PULSE) fire = pulse_hit;
            else                   fire = direct_hit(mode, ed);
        end
    end
endmodule

// File: rtl/icap_latch.sv
module icap_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [CNT_W-1:0] count_in,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] value,
    output logic             strobe,
    output logic             flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value  <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= fire;
            if (fire) value <= count_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (fire)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/icap_edge_unit.sv
module icap_edge_unit #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_en,
    input  logic [1:0]       cap_mode,
    input  logic             pin_async,
    input  logic [CNT_W-1:0] count_in,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_strobe,
    output logic             cap_flag
);
    logic pin_s;
    logic fire;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_async),
        .q_sync  (pin_s)
    );

    icap_edge_qual u_qual (
        .clk      (clk),
        .rst      (rst),
        .en       (chan_en),
        .mode_raw (cap_mode),
        .lvl      (pin_s),
        .fire     (fire)
    );

    icap_latch #(.CNT_W(CNT_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .count_in (count_in),
        .flag_clr (flag_clr),
        .value    (cap_value),
        .strobe   (cap_strobe),
        .flag     (cap_flag)
    );
endmodule

// File: rtl/icap_edge_unit_chk.sv
module icap_edge_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             chan_en,
    input logic [CNT_W-1:0] count_in,
    input logic             flag_clr,
    input logic [CNT_W-1:0] cap_value,
    input logic             cap_strobe,
    input logic             cap_flag
);
    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> !cap_strobe);

    // R8
    value_source_chk: assert property (@(posedge clk) disable iff (rst)
        cap_strobe |-> cap_value == $past(count_in));

    // R8
    value_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_strobe |-> $stable(cap_value));

    // R10
    flag_follows_chk: assert property (@(posedge clk) disable iff (rst)
        cap_strobe |-> cap_flag);

    // R10
    clear_result_chk: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> (cap_flag == cap_strobe));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!cap_strobe && !cap_flag && cap_value == '0));
endmodule

bind icap_edge_unit icap_edge_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chan_en    (chan_en),
    .count_in   (count_in),
    .flag_clr   (flag_clr),
    .cap_value  (cap_value),
    .cap_strobe (cap_strobe),
    .cap_flag   (cap_flag)
);

// File: tb/icap_edge_unit_tb.sv
`timescale 1ns/1ps
module icap_edge_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_en = 1'b0;
    logic [1:0]  cap_mode = 2'b00;
    logic        pin_async = 1'b0;
    logic [15:0] count_in = '0;
    logic        flag_clr = 1'b0;
    logic [15:0] cap_value;
    logic        cap_strobe;
    logic        cap_flag;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [15:0] last_cap = '0;
    logic        exp_flag = 1'b0;

    always #2.5 clk = ~clk;

    icap_edge_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .chan_en    (chan_en),
        .cap_mode   (cap_mode),
        .pin_async  (pin_async),
        .count_in   (count_in),
        .flag_clr   (flag_clr),
        .cap_value  (cap_value),
        .cap_strobe (cap_strobe),
        .cap_flag   (cap_flag)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Change the pin, then check strobe on the third edge (R9), value (R8) and flag (R10).
    task automatic step_pin(input logic v, input logic [15:0] cv, input logic exp_evt, input string req);
        @(negedge clk);
        pin_async = v;
        count_in  = cv;
        repeat (3) @(posedge clk);
        #1;
        check(cap_strobe == exp_evt, req, cap_strobe, exp_evt);
        if (exp_evt) begin
            last_cap = cv;
            exp_flag = 1'b1;
        end
        check(cap_value == last_cap, {req, " value R8"}, cap_value, last_cap);
        check(cap_flag == exp_flag, {req, " flag R10"}, cap_flag, exp_flag);
        @(posedge clk);
        #1;
        check(cap_strobe == 1'b0, "R9 strobe one cycle", cap_strobe, 0);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        cap_mode = m;
        repeat (2) @(posedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        exp_flag = 1'b0;
        check(cap_flag == 1'b0, "R10 clear", cap_flag, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cap_strobe == 1'b0 && cap_flag == 1'b0 && cap_value == 0, "R1 during reset",
              {cap_value, cap_strobe, cap_flag}, 0);
        rst = 1'b0;
        chan_en = 1'b1;
        @(negedge clk);
        check(cap_strobe == 1'b0 && cap_flag == 1'b0 && cap_value == 0, "R1 after reset",
              {cap_value, cap_strobe, cap_flag}, 0);
    endtask

    task automatic t_any();
        set_mode(2'b00);
        step_pin(1'b1, 16'h0101, 1'b1, "R2 rise");
        step_pin(1'b0, 16'h0102, 1'b1, "R2 fall");
        clear_flag();
    endtask

    task automatic t_rise();
        set_mode(2'b01);
        step_pin(1'b1, 16'h0201, 1'b1, "R3 rise");
        step_pin(1'b0, 16'h0202, 1'b0, "R3 fall ignored");
        clear_flag();
    endtask

    task automatic t_fall();
        set_mode(2'b10);
        step_pin(1'b1, 16'h0301, 1'b0, "R4 rise ignored");
        step_pin(1'b0, 16'h0302, 1'b1, "R4 fall");
        clear_flag();
    endtask

    task automatic t_pulse();
        set_mode(2'b11);
        step_pin(1'b1, 16'h0401, 1'b0, "R5 first edge arms");
        step_pin(1'b0, 16'h0402, 1'b1, "R5 second edge");
        step_pin(1'b1, 16'h0403, 1'b0, "R5 rearm");
        step_pin(1'b0, 16'h0404, 1'b1, "R5 second pulse");
        clear_flag();
    endtask

    task automatic t_mode_change();
        set_mode(2'b11);
        step_pin(1'b1, 16'h0501, 1'b0, "R6 arm");
        set_mode(2'b01);
        set_mode(2'b11);
        step_pin(1'b0, 16'h0502, 1'b0, "R6 arm dropped");
        step_pin(1'b1, 16'h0503, 1'b1, "R6 capture after rearm");
        step_pin(1'b0, 16'h0504, 1'b0, "R6 rearm");
        step_pin(1'b1, 16'h0505, 1'b1, "R6 capture");
        clear_flag();
        step_pin(1'b0, 16'h0506, 1'b0, "R6 arm again");
        step_pin(1'b1, 16'h0507, 1'b1, "R6 pair");
        clear_flag();
    endtask

    task automatic t_disable();
        set_mode(2'b00);
        @(negedge clk);
        chan_en = 1'b0;
        step_pin(1'b0, 16'h0601, 1'b0, "R7 disabled fall");
        step_pin(1'b1, 16'h0602, 1'b0, "R7 disabled rise");
        @(negedge clk);
        chan_en = 1'b1;
        set_mode(2'b11);
        step_pin(1'b0, 16'h0603, 1'b0, "R7 arm");
        @(negedge clk);
        chan_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chan_en = 1'b1;
        step_pin(1'b1, 16'h0604, 1'b0, "R7 arm cleared by disable");
        step_pin(1'b0, 16'h0605, 1'b1, "R7 capture after rearm");
        clear_flag();
    endtask

    task automatic t_flag();
        set_mode(2'b00);
        step_pin(1'b1, 16'h0701, 1'b1, "R10 set");
        repeat (5) @(posedge clk);
        #1;
        check(cap_flag == 1'b1, "R10 sticky", cap_flag, 1);
        clear_flag();
        @(negedge clk);
        pin_async = 1'b0;
        count_in = 16'h0702;
        repeat (2) @(posedge clk);
        #1;
        flag_clr = 1'b1;
        @(posedge clk);
        #1;
        flag_clr = 1'b0;
        last_cap = 16'h0702;
        check(cap_strobe == 1'b1, "R9 strobe with clear", cap_strobe, 1);
        check(cap_flag == 1'b1, "R10 set wins over clear", cap_flag, 1);
        check(cap_value == last_cap, "R8 value with clear", cap_value, last_cap);
        exp_flag = 1'b1;
        clear_flag();
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_any();
        t_rise();
        t_fall();
        t_pulse();
        t_mode_change();
        t_disable();
        t_flag();
        repeat (4) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule